// File: doc/BRIEF.md
# Multi-target I2C RAM address sequencer

This block supplies the RAM buffer address for an I2C target that answers to three target identities. Each identity owns a fixed region of a shared RAM. The controller sends an 8-bit word address, and the block loads it as the current pointer. The pointer then advances once for every completed data byte.

During writes the pointer wraps inside a page. A 2-bit setting chooses the page size. Bytes beyond the page length overwrite the start of the same page. During reads the pointer runs through the whole region of the selected target and wraps to the region start when it passes the region end. Targets 1 and 2 have 256-byte regions and target 3 has a 128-byte region. No output reports that a wrap happened.

The region index forms the upper bits of the RAM address. The controller never sends those bits. Bit-level I2C shifting, the RAM itself and any register access from software sit outside the block.

Top module: `multi_tgt_addr_seq`

## Requirements
- R1: After synchronous reset, `ram_addr` is 0.
- R2: When `ptr_load` is high at a clock edge, `ram_addr` becomes `{region, word_addr & rmask}` after that edge. `rmask` is 0xFF for targets 1 and 2, and 0x7F for target 3, so the address is reduced modulo 128.
- R3: `page_len` encodes the page size as 00=8, 01=16, 10=32 and 11=64 bytes. On a write byte (`byte_done` high, `rd_dir`=0) the low log2(page) pointer bits increment and wrap, and the upper bits stay fixed.
- R4: With an 8-byte page, a write run that starts at 0x0C visits 0x0C, 0x0D, 0x0E, 0x0F, 0x08, 0x09, 0x0A, 0x0B. With a 16-byte page, the run wraps from 0x0F to 0x00.
- R5: On a read byte (`rd_dir`=1), the pointer increments across page boundaries. Past 0xFF it wraps to 0x00 for targets 1 and 2. Past 0x7F it wraps to 0x00 for target 3.
- R6: `tgt_sel` values 0, 1 and 2 select targets 1, 2 and 3. `ram_addr[9:8]` equals that value. A `tgt_sel` of 3 acts as target 3.
- R7: When `ptr_load` and `byte_done` are both high in the same cycle, the load wins and no increment is applied.
- R8: With neither `ptr_load` nor `byte_done` high, the pointer holds. A change of `rd_dir` alone, as on a repeated start that reverses direction, leaves the address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tgt_sel | input | 2 | Addressed target identity (0..2; 3 treated as 2) |
| ptr_load | input | 1 | Load word address strobe |
| word_addr | input | 8 | Word address sent by the controller |
| rd_dir | input | 1 | Transfer direction, 1 = read |
| byte_done | input | 1 | One data byte completed |
| page_len | input | 2 | Page size code |
| ram_addr | output | 10 | Registered RAM address {region, pointer} |

## Verification
The hardest case to reach from the ports is a long write burst that wraps inside a page. A nearby case is a read run through the end of the smaller 128-byte region. Random stimulus seldom strings together enough consecutive bytes in one direction to reach either one. Directed runs therefore load a pointer close to a page end or region end and issue a long burst under each page code. Seeded random traffic then mixes loads, direction flips, target changes and simultaneous load-and-byte cycles.

// File: rtl/addr_seq_pkg.sv
package addr_seq_pkg;
  typedef enum logic {
    DIR_WR = 1'b0,
    DIR_RD = 1'b1
  } xfer_dir_e;

  localparam int unsigned WORD_AW      = 8;
  localparam int unsigned SMALL_AW     = 7;
  localparam int unsigned NUM_TGT      = 3;
  localparam int unsigned PAGE_MIN_LOG = 3;
endpackage

// File: rtl/seq_region_decode.sv
module seq_region_decode #(
  parameter int unsigned NTGT     = addr_seq_pkg::NUM_TGT,
  parameter int unsigned AW       = addr_seq_pkg::WORD_AW,
  parameter int unsigned SMALL_AW = addr_seq_pkg::SMALL_AW,
  parameter int unsigned RW       = 2
) (
  input  logic [RW-1:0] tgt_sel,
  output logic [RW-1:0] region_idx,
  output logic [AW-1:0] region_mask
);
  localparam logic [AW-1:0] FULL_MASK  = {AW{1'b1}};
  localparam logic [AW-1:0] SMALL_MASK = AW'((1 << SMALL_AW) - 1);

  logic [AW-1:0] mask_tab [NTGT];

  // last target owns the reduced region, all others the full one
  for (genvar g = 0; g < NTGT; g++) begin : g_mask
    if (g == NTGT - 1) begin : g_small
      assign mask_tab[g] = SMALL_MASK;
    end else begin : g_full
      assign mask_tab[g] = FULL_MASK;
    end
  end

  always_comb begin
    if (int'(tgt_sel) >= NTGT) region_idx = RW'(NTGT - 1);
    else                       region_idx = tgt_sel;
    region_mask = FULL_MASK;
    for (int i = 0; i < NTGT; i++)
      if (int'(region_idx) == i) region_mask = mask_tab[i];
  end
endmodule

// File: rtl/seq_page_mask.sv
module seq_page_mask #(
  parameter int unsigned AW        = addr_seq_pkg::WORD_AW,
  parameter int unsigned PLW       = 2,
  parameter int unsigned MIN_LOG   = addr_seq_pkg::PAGE_MIN_LOG
) (
  input  logic [PLW-1:0] page_len,
  output logic [AW-1:0]  page_mask
);
  localparam int unsigned NCODE = 1 << PLW;

  logic [AW-1:0] mask_tab [NCODE];

  for (genvar c = 0; c < NCODE; c++) begin : g_code
    localparam int unsigned LG = (MIN_LOG + c > AW) ? AW : MIN_LOG + c;
    assign mask_tab[c] = AW'((1 << LG) - 1);
  end

  assign page_mask = mask_tab[page_len];
endmodule

// File: rtl/seq_next_ptr.sv
module seq_next_ptr
  import addr_seq_pkg::*;
#(
  parameter int unsigned AW = WORD_AW
) (
  input  logic [AW-1:0] cur_ptr,
  input  xfer_dir_e     dir,
  input  logic [AW-1:0] page_mask,
  input  logic [AW-1:0] region_mask,
  output logic [AW-1:0] next_ptr
);
  logic [AW-1:0] inc;

  always_comb begin
    inc = cur_ptr + AW'(1);
    if (dir == DIR_WR)
      next_ptr = ((cur_ptr & ~page_mask) | (inc & page_mask)) & region_mask;
    else
      next_ptr = inc & region_mask;
  end
endmodule

// File: rtl/multi_tgt_addr_seq.sv
module multi_tgt_addr_seq
  import addr_seq_pkg::*;
#(
  parameter int unsigned AW  = WORD_AW,
  parameter int unsigned RW  = 2,
  parameter int unsigned PLW = 2,
  localparam int unsigned RAW = RW + AW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [RW-1:0]  tgt_sel,
  input  logic           ptr_load,
  input  logic [AW-1:0]  word_addr,
  input  logic           rd_dir,
  input  logic           byte_done,
  input  logic [PLW-1:0] page_len,
  output logic [RAW-1:0] ram_addr
);
  logic [RW-1:0]  region_idx;
  logic [AW-1:0]  region_mask;
  logic [AW-1:0]  page_mask;
  logic [AW-1:0]  ptr_q, ptr_d, adv_ptr;
  xfer_dir_e      dir;

  assign dir = rd_dir ? DIR_RD : DIR_WR;

  seq_region_decode #(.AW(AW), .RW(RW)) u_region (
    .tgt_sel     (tgt_sel),
    .region_idx  (region_idx),
    .region_mask (region_mask)
  );

  seq_page_mask #(.AW(AW), .PLW(PLW)) u_page (
    .page_len  (page_len),
    .page_mask (page_mask)
  );

  seq_next_ptr #(.AW(AW)) u_next (
    .cur_ptr     (ptr_q),
    .dir         (dir),
    .page_mask   (page_mask),
    .region_mask (region_mask),
    .next_ptr    (adv_ptr)
  );

  always_comb begin
    if (ptr_load)       ptr_d = word_addr & region_mask;
    else if (byte_done) ptr_d = adv_ptr;
    else                ptr_d = ptr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q    <= '0;
      ram_addr <= '0;
    end else begin
      ptr_q    <= ptr_d;
      ram_addr <= {region_idx, ptr_d & region_mask};
    end
  end

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    ptr_load |=> ptr_q == ($past(word_addr) & $past(region_mask)));

  // R3
  page_fixed_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_done && !ptr_load && !rd_dir) |=>
      ((ptr_q & ~$past(page_mask)) == ($past(ptr_q) & ~$past(page_mask) & $past(region_mask))));

  // R5
  read_step_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_done && !ptr_load && rd_dir) |=>
      ptr_q == (($past(ptr_q) + AW'(1)) & $past(region_mask)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!byte_done && !ptr_load) |=> ptr_q == $past(ptr_q));

  // R6
  region_range_chk: assert property (@(posedge clk) disable iff (rst)
    ram_addr[RAW-1 -: RW] != RW'(3));
endmodule

// File: tb/tb_multi_tgt_addr_seq.sv
module tb_multi_tgt_addr_seq;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] tgt_sel;
  logic       ptr_load;
  logic [7:0] word_addr;
  logic       rd_dir;
  logic       byte_done;
  logic [1:0] page_len;
  logic [9:0] ram_addr;

  int total = 0;
  int bad   = 0;
  logic [7:0] m_ptr;

  always #2 clk = ~clk;

  multi_tgt_addr_seq dut (
    .clk(clk), .rst(rst), .tgt_sel(tgt_sel), .ptr_load(ptr_load),
    .word_addr(word_addr), .rd_dir(rd_dir), .byte_done(byte_done),
    .page_len(page_len), .ram_addr(ram_addr)
  );

  function automatic logic [1:0] f_idx(input logic [1:0] t);
    return (t == 2'd3) ? 2'd2 : t;
  endfunction

  function automatic logic [7:0] f_rmask(input logic [1:0] t);
    return (f_idx(t) == 2'd2) ? 8'h7F : 8'hFF;
  endfunction

  function automatic logic [7:0] f_pmask(input logic [1:0] p);
    return 8'((8 << p) - 1);
  endfunction

  function automatic logic [7:0] f_next(input logic [7:0] p, input logic rd,
                                        input logic [1:0] pl, input logic [1:0] t);
    logic [7:0] n;
    if (rd) n = p + 8'd1;
    else    n = (p & ~f_pmask(pl)) | ((p + 8'd1) & f_pmask(pl));
    return n & f_rmask(t);
  endfunction

  task automatic check(input string req, input logic [9:0] exp);
    total++;
    if (ram_addr !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, ram_addr, exp);
    end
  endtask

  // inputs are driven at negedge; one posedge passes; sample at next negedge
  task automatic cyc(input logic [1:0] t, input logic ld, input logic [7:0] wa,
                     input logic rd, input logic bd, input logic [1:0] pl,
                     input string req);
    tgt_sel = t; ptr_load = ld; word_addr = wa; rd_dir = rd;
    byte_done = bd; page_len = pl;
    @(negedge clk);
    if (ld)      m_ptr = wa & f_rmask(t);
    else if (bd) m_ptr = f_next(m_ptr, rd, pl, t);
    check(req, {f_idx(t), m_ptr & f_rmask(t)});
  endtask

  task automatic expect_seq(input string req, input logic [7:0] a);
    total++;
    if (ram_addr[7:0] !== a) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, ram_addr[7:0], a);
    end
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] seq8 [8];
    void'($urandom(32'd1234));
    seq8 = '{8'h0C, 8'h0D, 8'h0E, 8'h0F, 8'h08, 8'h09, 8'h0A, 8'h0B};
    rst = 1'b1; tgt_sel = 0; ptr_load = 0; word_addr = 0; rd_dir = 0;
    byte_done = 0; page_len = 0; m_ptr = 0;
    @(negedge clk); @(negedge clk);
    check("R1", 10'h000);
    rst = 1'b0;

    // R4 8-byte page write run from 0x0C
    cyc(2'd0, 1, 8'h0C, 0, 0, 2'd0, "R2");
    expect_seq("R4", seq8[0]);
    for (int i = 1; i < 8; i++) begin
      cyc(2'd0, 0, 8'h00, 0, 1, 2'd0, "R3");
      expect_seq("R4", seq8[i]);
    end
    // R4 16-byte page wrap 0x0F -> 0x00
    cyc(2'd1, 1, 8'h0E, 0, 0, 2'd1, "R2");
    cyc(2'd1, 0, 8'h00, 0, 1, 2'd1, "R4");
    expect_seq("R4", 8'h0F);
    cyc(2'd1, 0, 8'h00, 0, 1, 2'd1, "R4");
    expect_seq("R4", 8'h00);
    // R3 64-byte page wrap 0x7F -> 0x40
    cyc(2'd0, 1, 8'h7F, 0, 0, 2'd3, "R2");
    cyc(2'd0, 0, 8'h00, 0, 1, 2'd3, "R3");
    expect_seq("R3", 8'h40);
    // R5 read wrap targets 1/2
    cyc(2'd1, 1, 8'hFE, 1, 0, 2'd0, "R2");
    cyc(2'd1, 0, 8'h00, 1, 1, 2'd0, "R5");
    cyc(2'd1, 0, 8'h00, 1, 1, 2'd0, "R5");
    expect_seq("R5", 8'h00);
    // R2 target 3 modulo 128, R5 wrap at 0x7F
    cyc(2'd2, 1, 8'hFF, 1, 0, 2'd0, "R2");
    expect_seq("R2", 8'h7F);
    cyc(2'd2, 0, 8'h00, 1, 1, 2'd0, "R5");
    check("R5", 10'h200);
    // R6 tgt_sel 3 acts as target 3
    cyc(2'd3, 1, 8'hC5, 0, 0, 2'd0, "R6");
    check("R6", 10'h245);
    // R7 load wins over byte_done
    cyc(2'd0, 1, 8'h33, 1, 1, 2'd0, "R7");
    check("R7", 10'h033);
    // R8 direction flip holds address
    cyc(2'd0, 0, 8'h99, 0, 0, 2'd2, "R8");
    cyc(2'd0, 0, 8'h99, 1, 0, 2'd2, "R8");
    check("R8", 10'h033);
    cyc(2'd0, 0, 8'h00, 1, 1, 2'd2, "R5");
    check("R5", 10'h034);

    // seeded random traffic with long same-direction bursts
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] t;
      logic ld, rd, bd;
      logic [1:0] pl;
      logic [7:0] wa;
      t  = 2'($urandom_range(0, 3));
      ld = ($urandom_range(0, 15) == 0);
      rd = ($urandom_range(0, 1) == 1);
      pl = 2'($urandom_range(0, 3));
      wa = 8'($urandom);
      for (int k = 0; k < int'($urandom_range(1, 20)); k++) begin
        bd = ($urandom_range(0, 3) != 0);
        cyc(t, (k == 0) ? ld : 1'b0, wa, rd, bd, pl,
            (k == 0 && ld) ? "R2" : (!bd ? "R8" : (rd ? "R5" : "R3")));
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule